// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block collects level-sensitive interrupt lines in groups of 32 and presents them to a processor as three request outputs: a normal interrupt request, a fast interrupt request and an endpoint request. The number of groups (banks) is set when the block is built. Every source line first passes through a two-stage synchronizer. The synchronized level is then the bank's cause word, which software can read but cannot change.

Each bank has three enable words, one for each output. A source reaches an output only when its bit is set in that output's enable word. Each output is the OR of (cause AND enable) across every bank. The block does no prioritisation, vectoring or latching. Software reads the cause words, ANDs them with its own copy of the enables and services whatever is pending. It does this through a plain register port: a write strobe, a read strobe, a byte address and a 32-bit data word.

Top module: `bank_intc`

## Requirements
- R1: A read of bank offset 0x00 returns that bank's cause word. Bit k of bank n is the synchronized level of `src_i[32n+k]`.
- R2: A change on a source line first shows in the cause word and the request outputs after exactly two rising clock edges. After one edge nothing has changed yet.
- R3: `irq_o` is high exactly when some bank has a bit set both in its cause word and in its normal enable word at offset 0x04.
- R4: `fiq_o` is high exactly when some bank has a bit set both in its cause word and in its fast enable word at offset 0x08. It does not depend on the normal enable words.
- R5: `endp_o` is high exactly when some bank has a bit set both in its cause word and in its endpoint enable word at offset 0x0c.
- R6: Reset clears all enable words and `rdata` to zero, so all three outputs are low after reset.
- R7: A write to a cause offset has no effect. The cause word still reads back the live source levels.
- R8: A read strobe captures the addressed register into `rdata` on that clock edge. `rdata` keeps its value while no read is strobed. An enable word reads back the last value written to it.
- R9: Bank n is at byte base n*0x10, with the register select in address bits [3:2]. An enable bit in one bank never passes a source that belongs to another bank.
- R10: Writing 0 to a bank's normal enable word masks all of that bank's sources from `irq_o`.
- R11: An access whose bank index is NUM_BANKS or above reads as zero, and a write to it changes no enable word.
- R12: Sources are not latched. A cause bit clears, and the request it drove drops, two edges after its line goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources, bit 32n+k is bank n bit k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address: bank index above bit 3, register select in bits [3:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| endp_o | output | 1 | Endpoint request |

## Verification
The case that is hardest to reach from the ports is a source that is pending in the cause word while every enable bit covering it is routed to the wrong bank or the wrong output. In that case an output must stay low even though a cause bit is set. The stimulus gets there by raising a line of the second bank, then setting the matching bit position in the first bank's normal enable word and in the second bank's fast enable word. It then checks that only the fast output rises. The two-edge synchronizer delay is checked by sampling the outputs after one edge and again after the second edge.

// File: rtl/bank_intc_pkg.sv
package bank_intc_pkg;

    localparam int SRC_PER_BANK  = 32;
    localparam int BANK_SPAN_LG2 = 4;

    typedef logic [SRC_PER_BANK-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_IRQ   = 2'd1,
        SEL_FIQ   = 2'd2,
        SEL_ENDP  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        word_t cause;
        word_t irq_m;
        word_t fiq_m;
        word_t endp_m;
    } bank_view_t;

    typedef struct packed {
        logic irq;
        logic fiq;
        logic endp;
    } req_t;

    function automatic word_t pick_word(bank_view_t v, reg_sel_e s);
        case (s)
            SEL_CAUSE: return v.cause;
            SEL_IRQ:   return v.irq_m;
            SEL_FIQ:   return v.fiq_m;
            default:   return v.endp_m;
        endcase
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import bank_intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  word_t      cause_i,
    input  logic       we,
    input  reg_sel_e   sel,
    input  word_t      wdata,
    output bank_view_t view_o,
    output req_t       req_o
);
    word_t irq_m, fiq_m, endp_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_m  <= '0;
            fiq_m  <= '0;
            endp_m <= '0;
        end else if (we) begin
            case (sel)
                SEL_IRQ:  irq_m  <= wdata;
                SEL_FIQ:  fiq_m  <= wdata;
                SEL_ENDP: endp_m <= wdata;
                default:  ; // cause is read-only
            endcase
        end
    end

    always_comb begin
        view_o.cause  = cause_i;
        view_o.irq_m  = irq_m;
        view_o.fiq_m  = fiq_m;
        view_o.endp_m = endp_m;
        req_o.irq     = |(cause_i & irq_m);
        req_o.fiq     = |(cause_i & fiq_m);
        req_o.endp    = |(cause_i & endp_m);
    end
endmodule

// File: rtl/bank_intc.sv
module bank_intc
    import bank_intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    output logic                           irq_o,
    output logic                           fiq_o,
    output logic                           endp_o
);
    localparam int TOTAL  = NUM_BANKS * SRC_PER_BANK;
    localparam int BIDX_W = ADDR_W - BANK_SPAN_LG2;

    logic [TOTAL-1:0]     src_sync;
    logic [BIDX_W-1:0]    bidx;
    reg_sel_e             sel;
    bank_view_t           view [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_vec, fiq_vec, endp_vec;
    logic [TOTAL-1:0]     irq_mask_all, fiq_mask_all;
    word_t                rd_word;

    assign bidx = addr[ADDR_W-1:BANK_SPAN_LG2];
    assign sel  = reg_sel_e'(addr[3:2]);

    intc_sync #(.W(TOTAL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (src_sync)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        req_t req;
        intc_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .cause_i (src_sync[g*SRC_PER_BANK +: SRC_PER_BANK]),
            .we      (wr_en && (bidx == BIDX_W'(g))),
            .sel     (sel),
            .wdata   (wdata),
            .view_o  (view[g]),
            .req_o   (req)
        );
        assign irq_vec[g]  = req.irq;
        assign fiq_vec[g]  = req.fiq;
        assign endp_vec[g] = req.endp;
        assign irq_mask_all[g*SRC_PER_BANK +: SRC_PER_BANK] = view[g].irq_m;
        assign fiq_mask_all[g*SRC_PER_BANK +: SRC_PER_BANK] = view[g].fiq_m;
    end

    assign irq_o  = |irq_vec;
    assign fiq_o  = |fiq_vec;
    assign endp_o = |endp_vec;

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bidx == BIDX_W'(i)) rd_word = pick_word(view[i], sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_BANKS*32-1:0] src_i,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [31:0]             rdata,
    input logic                    irq_o,
    input logic                    fiq_o,
    input logic                    endp_o,
    input logic [NUM_BANKS*32-1:0] irq_mask_all,
    input logic [NUM_BANKS*32-1:0] fiq_mask_all
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && !fiq_o && !endp_o && rdata == 32'd0)); // R6

    AST_QUIET_SOURCES: assert property (@(posedge clk) disable iff (rst)
        ($past(src_i, 2) == '0) |-> (!irq_o && !fiq_o && !endp_o)); // R2

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (irq_mask_all == '0) |-> !irq_o); // R3

    AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (fiq_mask_all == '0) |-> !fiq_o); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R8

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (32'(addr[ADDR_W-1:4]) >= NUM_BANKS)) |=> (rdata == 32'd0)); // R11
endmodule

bind bank_intc intc_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_i        (src_i),
    .rd_en        (rd_en),
    .addr         (addr),
    .rdata        (rdata),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .endp_o       (endp_o),
    .irq_mask_all (irq_mask_all),
    .fiq_mask_all (fiq_mask_all)
);

// File: tb/sim_bank_intc.sv
`timescale 1ns/1ps
module sim_bank_intc;
    localparam int NB = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB*32-1:0] src = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_o, fiq_o, endp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bank_intc #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
        .clk (clk), .rst (rst), .src_i (src), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .irq_o (irq_o), .fiq_o (fiq_o), .endp_o (endp_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_src(input logic [NB*32-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R6 irq after reset", {31'd0, irq_o}, 32'd0);
        check("R6 fiq after reset", {31'd0, fiq_o}, 32'd0);
        check("R6 rdata after reset", rdata, 32'd0);
        reg_rd(8'h14, d);
        check("R6 bank1 irq enable reset", d, 32'd0);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        reg_wr(8'h04, 32'h0000_0008);
        @(negedge clk);
        src = 64'h8;
        @(negedge clk);
        check("R2 irq after one edge", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        check("R2 R3 irq after two edges", {31'd0, irq_o}, 32'd1);
        reg_rd(8'h00, d);
        check("R1 bank0 cause", d, 32'h0000_0008);
    endtask

    task automatic t_level();
        logic [31:0] d;
        set_src(64'h0);
        check("R12 irq drops with source", {31'd0, irq_o}, 32'd0);
        reg_rd(8'h00, d);
        check("R12 cause cleared", d, 32'd0);
    endtask

    task automatic t_cross_bank();
        reg_wr(8'h04, 32'h0000_0020);
        reg_wr(8'h18, 32'h0000_0020);
        set_src(64'h1 << 37);
        check("R9 bank0 enable ignores bank1 source", {31'd0, irq_o}, 32'd0);
        check("R4 R9 fiq from bank1", {31'd0, fiq_o}, 32'd1);
        check("R5 endp still low", {31'd0, endp_o}, 32'd0);
        reg_wr(8'h1c, 32'h0000_0020);
        check("R5 endp from bank1", {31'd0, endp_o}, 32'd1);
    endtask

    task automatic t_cause_write();
        logic [31:0] d;
        reg_wr(8'h10, 32'hFFFF_FFFF);
        reg_rd(8'h10, d);
        check("R7 cause write ignored", d, 32'h0000_0020);
        reg_rd(8'h18, d);
        check("R8 fiq enable readback", d, 32'h0000_0020);
        @(negedge clk);
        check("R8 rdata held without read", rdata, 32'h0000_0020);
    endtask

    task automatic t_disable();
        reg_wr(8'h14, 32'hFFFF_FFFF);
        check("R3 bank1 irq enabled", {31'd0, irq_o}, 32'd1);
        reg_wr(8'h14, 32'h0);
        check("R10 zero enable masks irq", {31'd0, irq_o}, 32'd0);
        check("R4 fiq independent of irq enable", {31'd0, fiq_o}, 32'd1);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        reg_wr(8'h24, 32'hFFFF_FFFF);
        reg_rd(8'h24, d);
        check("R11 out-of-range read zero", d, 32'd0);
        check("R11 out-of-range write no irq", {31'd0, irq_o}, 32'd0);
        reg_rd(8'h04, d);
        check("R11 bank0 enable untouched", d, 32'h0000_0020);
        reg_rd(8'h14, d);
        check("R11 bank1 enable untouched", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sync();
        t_level();
        t_cross_bank();
        t_cause_write();
        t_disable();
        t_out_of_range();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule